// File: doc/BRIEF.md
# Flash Program-Launch Control Register

This block is the control register that stands between an 8-bit CPU bus and an on-chip flash array. A 2-bit space selector picks which flash space code-space reads see: the user space, the extra row or the hardware security byte. A page-buffer access bit sends CPU data writes below 4000h to the flash column latches instead of the data EEPROM. Each such write is split into a page number and a byte offset.

Programming starts only after a two-step key. A register write whose upper nibble is 5h arms the block. The next register write, with upper nibble Ah, fires a one-cycle launch pulse that carries the operation type and the page of the most recent latch write. Any other instruction between the two writes disarms the block. So does a write while the flash array reports busy. The CPU reports other instructions on a strobe.

The key logic is a three-state machine. KS_IDLE waits for a key. KS_ARMED holds a valid 5h write. KS_FIRE is the single cycle in which the launch pulse is high. The transitions are:
- arm: KS_IDLE or KS_FIRE to KS_ARMED, on a 5h write while not busy with no strobe.
- fire: KS_ARMED to KS_FIRE, on an Ah write while not busy, with no strobe and a selector other than 11.
- rearm: KS_ARMED stays in KS_ARMED on a further 5h write.
- abort: KS_ARMED to KS_IDLE, on the strobe, on any other register write, or on a write while busy.
- settle: KS_FIRE to KS_IDLE when no arming write arrives.

Top module: `flash_launch_ctrl`

## Requirements
- R1: After reset the selector is 00, the page-buffer access bit is clear, the block is disarmed, no launch pulse is driven, the launch page is 0 and reg_rdata reads 00h while flash_busy is low.
- R2: reg_rdata is {4'b0000, flash_busy, access bit, selector}. Bits 7:4 always read 0, and bit 3 follows flash_busy in the same cycle.
- R3: launch_pulse is high for exactly one cycle. That cycle is the one after a register write with bits 7:4 = Ah, when the block was armed by a write with bits 7:4 = 5h. Cycles with no instruction may separate the two writes.
- R4: Each of these leaves no launch and disarms the block: an other_insn strobe while armed (including in the same cycle as the Ah write, where the strobe wins), a register write with any other key while armed, or an Ah write while not armed. A further 5h write while armed keeps it armed.
- R5: launch_op equals the selector written by the firing Ah write: 00 user page write, 01 extra-row write, 10 security-bit write. Selector 11 produces no pulse and disarms.
- R6: A register write while flash_busy is high neither arms nor fires, and it disarms the block.
- R7: latch_we is high in the cycle of mem_wr when the access bit is set and mem_addr < 4000h. latch_off = mem_addr[6:0], latch_page = mem_addr[14:7] and latch_data = mem_wdata.
- R8: ee_we = mem_wr & ee_en & ~access bit. The set access bit overrides ee_en, and latch_we and ee_we are never both high.
- R9: launch_page is the page of the most recent latch write, including one in the same cycle as the firing write. It is held until the next launch.
- R10: Every register write loads the selector from bits 1:0 and the access bit from bit 2, whatever its key and whatever flash_busy is. The new values apply from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | CPU write to the control register |
| reg_wdata | input | 8 | Write data: key [7:4], access [2], selector [1:0] |
| reg_rdata | output | 8 | Register readback |
| other_insn | input | 1 | Strobe: an instruction other than a control-register write completed |
| flash_busy | input | 1 | Flash array busy |
| ee_en | input | 1 | Data-EEPROM write enable bit |
| mem_wr | input | 1 | CPU data write |
| mem_addr | input | 16 | CPU data write address |
| mem_wdata | input | 8 | CPU data write byte |
| space_sel | output | 2 | Flash space seen by code reads |
| latch_we | output | 1 | Column-latch write enable |
| latch_page | output | 8 | Page number of the latch write |
| latch_off | output | 7 | Byte offset within the page |
| latch_data | output | 8 | Byte written to the latch |
| ee_we | output | 1 | Data-EEPROM write enable |
| launch_pulse | output | 1 | One-cycle programming launch |
| launch_op | output | 2 | Operation type of the launch |
| launch_page | output | 8 | Page to program |

## Verification
Two pairs of functions can meet in one cycle. The firing Ah write can coincide with an other_insn strobe, where the abort must win and no pulse may follow. It can also coincide with a column-latch write, where the launched page must be that write's page and not the older one. The bench drives both collisions as directed cases and again at random. A behavioural reference model predicts each cycle's outputs, and the bench compares them on every falling edge.

// File: rtl/flc_pkg.sv
package flc_pkg;
    typedef enum logic [1:0] {
        KS_IDLE  = 2'd0,
        KS_ARMED = 2'd1,
        KS_FIRE  = 2'd2
    } key_state_t;

    typedef enum logic [1:0] {
        SP_USER   = 2'b00,
        SP_EXTRA  = 2'b01,
        SP_SECURE = 2'b10,
        SP_RSVD   = 2'b11
    } space_t;

    localparam logic [3:0] KEY_ARM  = 4'h5;
    localparam logic [3:0] KEY_FIRE = 4'hA;
endpackage

// File: rtl/flc_ctrl_reg.sv
module flc_ctrl_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [2:0] wr_fields,
    input  logic       flash_busy,
    output logic [1:0] space_sel,
    output logic       buf_access,
    output logic [7:0] reg_rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            space_sel  <= flc_pkg::SP_USER;
            buf_access <= 1'b0;
        end else if (reg_wr) begin
            space_sel  <= wr_fields[1:0];
            buf_access <= wr_fields[2];
        end
    end

    always_comb begin
        reg_rdata = {4'b0000, flash_busy, buf_access, space_sel};
    end
endmodule

// File: rtl/flc_latch_route.sv
module flc_latch_route #(
    parameter int ADDR_W     = 16,
    parameter int OFF_W      = 7,
    parameter int PAGE_W     = 8,
    parameter int DATA_W     = 8,
    parameter int LATCH_SPAN = 16'h4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_wr,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    input  logic              buf_access,
    input  logic              ee_en,
    output logic              latch_we,
    output logic [PAGE_W-1:0] latch_page,
    output logic [OFF_W-1:0]  latch_off,
    output logic [DATA_W-1:0] latch_data,
    output logic              ee_we,
    output logic [PAGE_W-1:0] page_src
);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(LATCH_SPAN);

    logic [PAGE_W-1:0] last_page;
    logic              in_window;

    always_comb begin
        in_window  = (mem_addr < SPAN);
        latch_we   = mem_wr && buf_access && in_window;
        ee_we      = mem_wr && ee_en && !buf_access;
        latch_off  = mem_addr[OFF_W-1:0];
        latch_page = mem_addr[OFF_W +: PAGE_W];
        latch_data = mem_wdata;
        page_src   = latch_we ? latch_page : last_page;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_page <= '0;
        end else if (latch_we) begin
            last_page <= latch_page;
        end
    end
endmodule

// File: rtl/flc_key_fsm.sv
module flc_key_fsm #(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        key_nib,
    input  logic [1:0]        sel_in,
    input  logic              other_insn,
    input  logic              flash_busy,
    input  logic [PAGE_W-1:0] page_src,
    output logic              launch_pulse,
    output logic [1:0]        launch_op,
    output logic [PAGE_W-1:0] launch_page
);
    import flc_pkg::*;

    key_state_t state_q, state_nx;
    logic       arm_req;

    always_comb begin
        arm_req  = reg_wr && !other_insn && !flash_busy && (key_nib == KEY_ARM);
        state_nx = KS_IDLE;
        unique case (state_q)
            KS_IDLE, KS_FIRE: begin
                state_nx = arm_req ? KS_ARMED : KS_IDLE;
            end
            KS_ARMED: begin
                if (other_insn) begin
                    state_nx = KS_IDLE;
                end else if (reg_wr) begin
                    if (!flash_busy && key_nib == KEY_FIRE && sel_in != SP_RSVD)
                        state_nx = KS_FIRE;
                    else if (arm_req)
                        state_nx = KS_ARMED;
                    else
                        state_nx = KS_IDLE;
                end else begin
                    state_nx = KS_ARMED;
                end
            end
            default: state_nx = KS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KS_IDLE;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            launch_pulse <= 1'b0;
            launch_op    <= 2'b00;
            launch_page  <= '0;
        end else begin
            launch_pulse <= (state_nx == KS_FIRE);
            if (state_nx == KS_FIRE) begin
                launch_op   <= sel_in;
                launch_page <= page_src;
            end
        end
    end
endmodule

// File: rtl/flash_launch_ctrl.sv
module flash_launch_ctrl #(
    parameter int ADDR_W     = 16,
    parameter int OFF_W      = 7,
    parameter int PAGE_W     = 8,
    parameter int DATA_W     = 8,
    parameter int LATCH_SPAN = 16'h4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              other_insn,
    input  logic              flash_busy,
    input  logic              ee_en,
    input  logic              mem_wr,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    output logic [1:0]        space_sel,
    output logic              latch_we,
    output logic [PAGE_W-1:0] latch_page,
    output logic [OFF_W-1:0]  latch_off,
    output logic [DATA_W-1:0] latch_data,
    output logic              ee_we,
    output logic              launch_pulse,
    output logic [1:0]        launch_op,
    output logic [PAGE_W-1:0] launch_page
);
    logic              buf_access;
    logic [PAGE_W-1:0] page_src;
    logic              unused_busy_bit;

    assign unused_busy_bit = reg_wdata[3];

    flc_ctrl_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .wr_fields  (reg_wdata[2:0]),
        .flash_busy (flash_busy),
        .space_sel  (space_sel),
        .buf_access (buf_access),
        .reg_rdata  (reg_rdata)
    );

    flc_latch_route #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .PAGE_W(PAGE_W),
        .DATA_W(DATA_W), .LATCH_SPAN(LATCH_SPAN)
    ) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_wr     (mem_wr),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .buf_access (buf_access),
        .ee_en      (ee_en),
        .latch_we   (latch_we),
        .latch_page (latch_page),
        .latch_off  (latch_off),
        .latch_data (latch_data),
        .ee_we      (ee_we),
        .page_src   (page_src)
    );

    flc_key_fsm #(.PAGE_W(PAGE_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .key_nib      (reg_wdata[7:4]),
        .sel_in       (reg_wdata[1:0]),
        .other_insn   (other_insn),
        .flash_busy   (flash_busy),
        .page_src     (page_src),
        .launch_pulse (launch_pulse),
        .launch_op    (launch_op),
        .launch_page  (launch_page)
    );
endmodule

// File: rtl/flc_checker.sv
module flc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       other_insn,
    input logic       flash_busy,
    input logic       mem_wr,
    input logic       latch_we,
    input logic       ee_we,
    input logic       launch_pulse,
    input logic [1:0] launch_op
);
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        launch_pulse |=> !launch_pulse);

    a_r3_fire_key: assert property (@(posedge clk) disable iff (!rst_n)
        launch_pulse |-> ($past(reg_wr) && $past(reg_wdata[7:4]) == 4'hA));

    a_r4_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        launch_pulse |-> !$past(other_insn));

    a_r5_not_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        launch_pulse |-> (launch_op != 2'b11));

    a_r6_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        launch_pulse |-> !$past(flash_busy));

    a_r7_latch_gate: assert property (@(posedge clk) disable iff (!rst_n)
        latch_we |-> (mem_wr && reg_rdata[2]));

    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(latch_we && ee_we));

    a_r2_key_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7:4] == 4'h0);
endmodule

bind flash_launch_ctrl flc_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .other_insn   (other_insn),
    .flash_busy   (flash_busy),
    .mem_wr       (mem_wr),
    .latch_we     (latch_we),
    .ee_we        (ee_we),
    .launch_pulse (launch_pulse),
    .launch_op    (launch_op)
);

// File: tb/flash_launch_ctrl_tb.sv
module flash_launch_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        other_insn = 1'b0;
    logic        flash_busy = 1'b0;
    logic        ee_en = 1'b0;
    logic        mem_wr = 1'b0;
    logic [15:0] mem_addr = 16'h0;
    logic [7:0]  mem_wdata = 8'h00;
    logic [1:0]  space_sel;
    logic        latch_we;
    logic [7:0]  latch_page;
    logic [6:0]  latch_off;
    logic [7:0]  latch_data;
    logic        ee_we;
    logic        launch_pulse;
    logic [1:0]  launch_op;
    logic [7:0]  launch_page;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int ops_seen [4];
    bit running = 1'b0;

    // reference model state
    bit       m_armed;
    bit       m_fps;
    bit [1:0] m_sel;
    bit       m_pulse;
    bit [1:0] m_op;
    bit [7:0] m_page;
    bit [7:0] m_last;

    always #4 clk = ~clk;

    flash_launch_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .other_insn(other_insn), .flash_busy(flash_busy),
        .ee_en(ee_en), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .space_sel(space_sel), .latch_we(latch_we), .latch_page(latch_page),
        .latch_off(latch_off), .latch_data(latch_data), .ee_we(ee_we),
        .launch_pulse(launch_pulse), .launch_op(launch_op), .launch_page(launch_page)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        bit lw;
        bit [7:0] psrc;
        bit fire;
        cycles++;
        if (!rst_n) begin
            m_armed = 0; m_fps = 0; m_sel = 0; m_pulse = 0;
            m_op = 0; m_page = 0; m_last = 0;
        end else begin
            lw   = mem_wr && m_fps && (mem_addr < 16'h4000);
            psrc = lw ? mem_addr[14:7] : m_last;
            fire = reg_wr && m_armed && !other_insn && !flash_busy &&
                   reg_wdata[7:4] == 4'hA && reg_wdata[1:0] != 2'b11;
            m_pulse = fire;
            if (fire) begin
                m_op = reg_wdata[1:0];
                m_page = psrc;
            end
            if (other_insn) m_armed = 0;
            else if (reg_wr) m_armed = (reg_wdata[7:4] == 4'h5) && !flash_busy;
            if (lw) m_last = mem_addr[14:7];
            if (reg_wr) begin
                m_sel = reg_wdata[1:0];
                m_fps = reg_wdata[2];
            end
        end
    end

    always @(negedge clk) begin
        bit e_lw;
        if (running) begin
            e_lw = mem_wr && m_fps && (mem_addr < 16'h4000);
            chk(reg_rdata == {4'b0, flash_busy, m_fps, m_sel}, "R2/R10 reg_rdata", reg_rdata,
                {4'b0, flash_busy, m_fps, m_sel});
            chk(space_sel == m_sel, "R10 space_sel", space_sel, m_sel);
            chk(latch_we == e_lw, "R7 latch_we", latch_we, e_lw);
            if (e_lw) begin
                chk(latch_page == mem_addr[14:7] && latch_off == mem_addr[6:0] &&
                    latch_data == mem_wdata, "R7 latch fields",
                    {latch_page, latch_off, latch_data}, {mem_addr[14:7], mem_addr[6:0], mem_wdata});
            end
            chk(ee_we == (mem_wr && ee_en && !m_fps), "R8 ee_we", ee_we,
                mem_wr && ee_en && !m_fps);
            chk(launch_pulse == m_pulse, "R3/R4/R6 launch_pulse", launch_pulse, m_pulse);
            if (m_pulse) begin
                chk(launch_op == m_op, "R5 launch_op", launch_op, m_op);
                ops_seen[launch_op]++;
            end
            chk(launch_page == m_page, "R9 launch_page", launch_page, m_page);
        end
    end

    always @(posedge clk) begin
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic step(input bit rw, input logic [7:0] wd, input bit oi,
                        input bit mw, input logic [15:0] a, input logic [7:0] d);
        reg_wr = rw; reg_wdata = wd; other_insn = oi;
        mem_wr = mw; mem_addr = a; mem_wdata = d;
        @(posedge clk); #1;
        reg_wr = 0; reg_wdata = 0; other_insn = 0; mem_wr = 0; mem_addr = 0; mem_wdata = 0;
    endtask

    task automatic wreg(input logic [7:0] v); step(1, v, 0, 0, 16'h0, 8'h0); endtask
    task automatic idle();                     step(0, 8'h0, 0, 0, 16'h0, 8'h0); endtask
    task automatic insn();                     step(0, 8'h0, 1, 0, 16'h0, 8'h0); endtask
    task automatic mwr(input logic [15:0] a, input logic [7:0] d); step(0, 8'h0, 0, 1, a, d); endtask

    initial begin
        for (int i = 0; i < 4; i++) ops_seen[i] = 0;
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        chk(reg_rdata == 8'h00, "R1 reset reg_rdata", reg_rdata, 0);
        chk(launch_pulse == 1'b0, "R1 reset launch_pulse", launch_pulse, 0);
        chk(launch_page == 8'h00, "R1 reset launch_page", launch_page, 0);
        chk(space_sel == 2'b00, "R1 reset space_sel", space_sel, 0);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #1;
        running = 1;

        // R7, R9: latch writes with access bit set, then user launch
        wreg(8'h04);
        mwr(16'h0083, 8'h11);
        mwr(16'h3FFF, 8'h22);
        mwr(16'h4000, 8'h33);          // outside window
        wreg(8'h54); wreg(8'hA4); idle(); idle();
        // R5: extra row and security
        wreg(8'h55); wreg(8'hA5); idle();
        wreg(8'h56); wreg(8'hA6); idle();
        // R5: reserved selector
        wreg(8'h57); wreg(8'hA7); idle();
        // R4: intervening instruction, stray key, Ah alone, rearm
        wreg(8'h54); insn(); wreg(8'hA4); idle();
        wreg(8'h54); wreg(8'h34); wreg(8'hA4); idle();
        wreg(8'hA4); idle();
        wreg(8'h54); wreg(8'h54); wreg(8'hA4); idle();
        // R3: idle cycles between key writes
        wreg(8'h54); idle(); idle(); wreg(8'hA5); idle();
        // R6: busy blocks arming and firing
        flash_busy = 1; wreg(8'h54); flash_busy = 0; wreg(8'hA4); idle();
        wreg(8'h54); flash_busy = 1; wreg(8'hA4); flash_busy = 0; idle();
        wreg(8'h54); flash_busy = 1; idle(); flash_busy = 0; wreg(8'hA4); idle();
        // collisions: strobe with Ah write, latch write with Ah write
        wreg(8'h54); step(1, 8'hA4, 1, 0, 16'h0, 8'h0); idle();
        wreg(8'h54); step(1, 8'hA4, 0, 1, 16'h1280, 8'h5A); idle();
        // R8: access bit overrides ee_en
        ee_en = 1; mwr(16'h0100, 8'h44);
        wreg(8'h00); mwr(16'h0100, 8'h45); mwr(16'h8000, 8'h46);
        ee_en = 0; idle();

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int r;
            logic [7:0] wd;
            r = $urandom_range(0, 9);
            wd = $urandom;
            case ($urandom_range(0, 3))
                0: wd[7:4] = 4'h5;
                1: wd[7:4] = 4'hA;
                default: ;
            endcase
            if ($urandom_range(0, 3) != 0) wd[2] = 1'b1;
            flash_busy = ($urandom_range(0, 9) == 0);
            ee_en = $urandom_range(0, 1);
            step(r < 6, wd, r == 6 || ($urandom_range(0, 19) == 0),
                 r >= 5 || ($urandom_range(0, 3) == 0),
                 16'($urandom_range(0, 16'h5FFF)), 8'($urandom));
        end
        flash_busy = 0; ee_en = 0;
        idle(); idle();
        running = 0;
        chk(ops_seen[0] > 0, "R5 user op seen", ops_seen[0], 1);
        chk(ops_seen[1] > 0, "R5 extra-row op seen", ops_seen[1], 1);
        chk(ops_seen[2] > 0, "R5 security op seen", ops_seen[2], 1);
        chk(ops_seen[3] == 0, "R5 reserved op never launched", ops_seen[3], 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule